// File: doc/BRIEF.md
# Serial Flash Host Command Sequencer

This block is the host side of a serial flash link. A client issues one request: a normal read, a fast read, a 4 KB small-sector erase or a 64 KB sector erase. The request carries a 24-bit address and a byte count. The sequencer then builds the whole serial transaction on a mode-0 SPI bus. It drives the chip select, a serial clock divided down from the system clock, and the outgoing data line. It samples the incoming data line.

Read data comes back one byte at a time on a strobed output. Each erase is wrapped in three frames:

1. A one-byte write-enable frame.
2. The erase frame itself, ended exactly after the last address bit.
3. A status-polling frame, which the sequencer keeps open until the flash stops reporting busy.

A single done pulse closes every request. It is raised only after chip select has stayed high for the minimum gap.

Top module: `sfh_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 0, and neither `rsp_valid` nor `rsp_done` is asserted.
- R2: A request with `req_op` = 0 sends one frame: byte 03h, then the three address bytes with the high byte first, then `req_len` further bytes. Each received byte appears on `rsp_data` with a one-cycle `rsp_valid`. Bytes are delivered in bus order, and each is assembled from the bus most significant bit first.
- R3: A request with `req_op` = 1 sends 0Bh and the three address bytes, then eight dummy clocks whose input bits are discarded, then `req_len` data bytes delivered as in R2.
- R4: A request with `req_op` = 2 (opcode 20h) or `req_op` = 3 (opcode D8h) first sends a separate 8-clock frame carrying 06h. It then sends the erase frame: the opcode plus the three address bytes. Chip select rises after exactly 32 clocks of that frame.
- R5: After an erase frame, the sequencer opens a frame with opcode 05h. It keeps reading status bytes while bit 0 of the byte is 1, and it closes the frame after the first byte whose bit 0 is 0.
- R6: The bus runs in mode 0. `spi_sck` is low whenever `spi_cs_n` is high. Every high phase of `spi_sck` lasts exactly `HALF_DIV` system clocks, and every low phase lasts at least `HALF_DIV`. Input bits are sampled on the rising edge.
- R7: Chip select stays high for at least 4*`HALF_DIV` system clocks, which is two serial clock periods, between any two frames.
- R8: `rsp_done` is a single-cycle pulse given once per accepted request. It is raised after the closing chip-select gap of R7 has elapsed, with `spi_cs_n` high.
- R9: A `req_start` that arrives while a request is in progress is ignored. No extra frame and no extra done pulse follow from it.
- R10: A read or fast read with `req_len` = 0 ends after its header (32 clocks for 03h, 40 for 0Bh). It produces no `rsp_valid` and one `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request strobe, accepted only when idle |
| req_op | input | 2 | 0 read, 1 fast read, 2 small-sector erase, 3 sector erase |
| req_addr | input | 24 | Flash byte address |
| req_len | input | CNT_W | Number of bytes to read (reads only) |
| rsp_valid | output | 1 | One-cycle strobe for a received data byte |
| rsp_data | output | 8 | Received data byte |
| rsp_done | output | 1 | One-cycle pulse when the sequencer returns to idle |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume `HALF_DIV` is at least 2. They also assume the client never expects a start to be queued; a start that arrives while the sequencer is busy is simply dropped. The bench models the flash at the pins and only changes `spi_miso` after a falling serial clock edge, so every sampled bit is stable across the rising edge. Its status responses set bit 0 for a chosen number of polls and then clear it. Requests are issued only after the previous done pulse, except in the one deliberate intrusion test of R9.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_FAST  = 2'd1,
        REQ_SSE   = 2'd2,
        REQ_SE    = 2'd3
    } req_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WEN,
        ST_OPC,
        ST_ADR,
        ST_DMY,
        ST_DAT,
        ST_PCMD,
        ST_PDAT,
        ST_GAP
    } seq_st_e;

    localparam logic [7:0] CMD_WEN  = 8'h06;
    localparam logic [7:0] CMD_STAT = 8'h05;
    localparam logic [7:0] CMD_RD   = 8'h03;
    localparam logic [7:0] CMD_FRD  = 8'h0B;
    localparam logic [7:0] CMD_SSE  = 8'h20;
    localparam logic [7:0] CMD_SE   = 8'hD8;

    function automatic logic [7:0] opcode_for(req_op_e o);
        case (o)
            REQ_READ: return CMD_RD;
            REQ_FAST: return CMD_FRD;
            REQ_SSE:  return CMD_SSE;
            default:  return CMD_SE;
        endcase
    endfunction

    function automatic logic is_erase(req_op_e o);
        return (o == REQ_SSE) || (o == REQ_SE);
    endfunction

endpackage

// File: rtl/sfh_byte_eng.sv
module sfh_byte_eng #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = $clog2(HALF_DIV + 1);

    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;
    logic          sck_q;
    logic          busy_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            sck_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                busy_q  <= 1'b1;
                tx_sr   <= tx;
                bit_cnt <= '0;
                div_cnt <= '0;
                sck_q   <= 1'b0;
            end else if (busy_q) begin
                if (div_cnt == DW'(HALF_DIV - 1)) begin
                    div_cnt <= '0;
                    if (!sck_q) begin
                        // rising edge: sample the incoming line
                        sck_q <= 1'b1;
                        rx_sr <= {rx_sr[6:0], miso};
                    end else begin
                        // falling edge: advance to the next outgoing bit
                        sck_q <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sr   <= {tx_sr[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DW'(1);
                end
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = busy_q ? tx_sr[7] : 1'b0;
    assign busy = busy_q;
    assign done = done_q;
    assign rx   = rx_sr;

    // R6: a serial clock level never lasts a single system clock
    a_r6_min_phase: assert property (@(posedge clk) disable iff (rst)
        (sck_q != $past(sck_q)) |=> $stable(sck_q));

    // R4: the byte finishes with the serial clock low
    a_r4_done_low: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sck_q && !busy_q));

endmodule

// File: rtl/sfh_ctrl.sv
module sfh_ctrl
    import sfh_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int GAP_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [23:0]      addr,
    input  logic [CNT_W-1:0] len,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx,
    output logic             eng_go,
    output logic [7:0]       eng_tx,
    output logic             cs_n,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_done
);
    localparam int GW = $clog2(GAP_CLKS + 1);

    seq_st_e          st;
    seq_st_e          after_gap;
    req_op_e          op_q;
    logic [23:0]      addr_q;
    logic [CNT_W-1:0] left;
    logic [1:0]       aidx;
    logic [GW-1:0]    gcnt;
    logic             go_q;
    logic [7:0]       tx_q;
    logic             cs_q;
    logic             val_q;
    logic [7:0]       dat_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            after_gap <= ST_IDLE;
            op_q      <= REQ_READ;
            addr_q    <= '0;
            left      <= '0;
            aidx      <= '0;
            gcnt      <= '0;
            go_q      <= 1'b0;
            tx_q      <= '0;
            cs_q      <= 1'b1;
            val_q     <= 1'b0;
            dat_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            val_q  <= 1'b0;
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= req_op_e'(op);
                        addr_q <= addr;
                        left   <= len;
                        cs_q   <= 1'b0;
                        go_q   <= 1'b1;
                        if (is_erase(req_op_e'(op))) begin
                            tx_q <= CMD_WEN;
                            st   <= ST_WEN;
                        end else begin
                            tx_q <= opcode_for(req_op_e'(op));
                            st   <= ST_OPC;
                        end
                    end
                end
                ST_WEN: begin
                    if (eng_done) begin
                        cs_q      <= 1'b1;
                        gcnt      <= '0;
                        after_gap <= ST_OPC;
                        st        <= ST_GAP;
                    end
                end
                ST_OPC: begin
                    if (eng_done) begin
                        go_q <= 1'b1;
                        tx_q <= addr_q[23:16];
                        aidx <= 2'd1;
                        st   <= ST_ADR;
                    end
                end
                ST_ADR: begin
                    if (eng_done) begin
                        if (aidx == 2'd1) begin
                            go_q <= 1'b1;
                            tx_q <= addr_q[15:8];
                            aidx <= 2'd2;
                        end else if (aidx == 2'd2) begin
                            go_q <= 1'b1;
                            tx_q <= addr_q[7:0];
                            aidx <= 2'd3;
                        end else if (is_erase(op_q)) begin
                            // erase starts on this chip-select rise
                            cs_q      <= 1'b1;
                            gcnt      <= '0;
                            after_gap <= ST_PCMD;
                            st        <= ST_GAP;
                        end else if (op_q == REQ_FAST) begin
                            go_q <= 1'b1;
                            tx_q <= 8'h00;
                            st   <= ST_DMY;
                        end else if (left == '0) begin
                            cs_q      <= 1'b1;
                            gcnt      <= '0;
                            after_gap <= ST_IDLE;
                            st        <= ST_GAP;
                        end else begin
                            go_q <= 1'b1;
                            tx_q <= 8'h00;
                            st   <= ST_DAT;
                        end
                    end
                end
                ST_DMY: begin
                    if (eng_done) begin
                        if (left == '0) begin
                            cs_q      <= 1'b1;
                            gcnt      <= '0;
                            after_gap <= ST_IDLE;
                            st        <= ST_GAP;
                        end else begin
                            go_q <= 1'b1;
                            tx_q <= 8'h00;
                            st   <= ST_DAT;
                        end
                    end
                end
                ST_DAT: begin
                    if (eng_done) begin
                        val_q <= 1'b1;
                        dat_q <= eng_rx;
                        left  <= left - CNT_W'(1);
                        if (left == CNT_W'(1)) begin
                            cs_q      <= 1'b1;
                            gcnt      <= '0;
                            after_gap <= ST_IDLE;
                            st        <= ST_GAP;
                        end else begin
                            go_q <= 1'b1;
                            tx_q <= 8'h00;
                        end
                    end
                end
                ST_PCMD: begin
                    if (eng_done) begin
                        go_q <= 1'b1;
                        tx_q <= 8'h00;
                        st   <= ST_PDAT;
                    end
                end
                ST_PDAT: begin
                    if (eng_done) begin
                        if (eng_rx[0]) begin
                            go_q <= 1'b1;
                            tx_q <= 8'h00;
                        end else begin
                            cs_q      <= 1'b1;
                            gcnt      <= '0;
                            after_gap <= ST_IDLE;
                            st        <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt == GW'(GAP_CLKS - 1)) begin
                        case (after_gap)
                            ST_OPC: begin
                                cs_q <= 1'b0;
                                go_q <= 1'b1;
                                tx_q <= opcode_for(op_q);
                                st   <= ST_OPC;
                            end
                            ST_PCMD: begin
                                cs_q <= 1'b0;
                                go_q <= 1'b1;
                                tx_q <= CMD_STAT;
                                st   <= ST_PCMD;
                            end
                            default: begin
                                done_q <= 1'b1;
                                st     <= ST_IDLE;
                            end
                        endcase
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign eng_go    = go_q;
    assign eng_tx    = tx_q;
    assign cs_n      = cs_q;
    assign rsp_valid = val_q;
    assign rsp_data  = dat_q;
    assign rsp_done  = done_q;

    // R9: a start while busy leaves the latched request untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && st != ST_IDLE) |=> ($stable(op_q) && $stable(addr_q)));

    // R8: done is a single-cycle pulse seen with chip select high
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r8_done_cs_high: assert property (@(posedge clk) disable iff (rst)
        done_q |-> cs_q);

    // R2: each data strobe lasts one cycle
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        val_q |=> !val_q);

endmodule

// File: rtl/sfh_seq.sv
module sfh_seq
    import sfh_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_start,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [CNT_W-1:0] req_len,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_done,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int GAP_CLKS = 4 * HALF_DIV;
    localparam int HW       = $clog2(GAP_CLKS + 2);

    logic       eng_go;
    logic [7:0] eng_tx;
    logic       eng_busy;
    logic       eng_done;
    logic [7:0] eng_rx;

    sfh_ctrl #(
        .CNT_W    (CNT_W),
        .GAP_CLKS (GAP_CLKS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (req_start),
        .op        (req_op),
        .addr      (req_addr),
        .len       (req_len),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .eng_go    (eng_go),
        .eng_tx    (eng_tx),
        .cs_n      (spi_cs_n),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_done  (rsp_done)
    );

    sfh_byte_eng #(
        .HALF_DIV (HALF_DIV)
    ) u_eng (
        .clk  (clk),
        .rst  (rst),
        .go   (eng_go),
        .tx   (eng_tx),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .busy (eng_busy),
        .done (eng_done),
        .rx   (eng_rx)
    );

    // chip-select high-time tracker for the gap check
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= HW'(GAP_CLKS);
        end else if (spi_cs_n) begin
            if (hi_cnt < HW'(GAP_CLKS)) hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    // R6: serial clock idles low outside a frame
    a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R7: minimum chip-select high time before a new frame
    a_r7_cs_gap: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && $past(spi_cs_n)) |-> (hi_cnt >= HW'(GAP_CLKS)));

    // R4: a frame closes only on a byte boundary with the clock low
    a_r4_close_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (!eng_busy && !spi_sck));

    // R6: the shifter runs only inside a frame
    a_r6_busy_in_frame: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !spi_cs_n);

endmodule

// File: tb/sfh_seq_tb.sv
module sfh_seq_tb;
    localparam int HALF_DIV = 2;
    localparam int CNT_W    = 8;
    localparam int GAP      = 4 * HALF_DIV;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_start = 1'b0;
    logic [1:0]       req_op = '0;
    logic [23:0]      req_addr = '0;
    logic [CNT_W-1:0] req_len = '0;
    logic             rsp_valid, rsp_done, spi_sck, spi_cs_n, spi_mosi;
    logic [7:0]       rsp_data;
    logic             spi_miso = 1'b0;

    always #4 clk = ~clk;

    sfh_seq #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_err = 0;

    function automatic logic [7:0] mem_at(logic [23:0] a);
        return a[7:0] ^ (a[15:8] + 8'h3C) ^ {a[19:16], a[23:20]};
    endfunction

    // flash model and response monitor, all sampled at the falling clk edge
    logic        prev_sck = 1'b0, prev_cs = 1'b1;
    int          nr = 0, nbytes = 0;
    logic [7:0]  in_sr = '0, out_b = '0;
    logic [7:0]  fb [0:7];
    logic [7:0]  log_op [0:7];
    logic [23:0] log_addr [0:7];
    int          log_bits [0:7];
    int          nf = 0, nrx = 0, ndone = 0;
    logic [7:0]  rx_buf [0:15];
    int          busy_cfg = 0, busy_left = 0;
    logic        wel = 1'b0;
    int          hi_run = 1000, gap_bad = 0, done_bad = 0;
    int          ph_cnt = 0, ph_bad = 0, idle_sck_bad = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_cs_n && spi_sck) idle_sck_bad++;
            if (prev_cs && !spi_cs_n) begin
                if (hi_run < GAP) gap_bad++;
                nr = 0; nbytes = 0; in_sr = '0; out_b = '0;
                for (int i = 0; i < 8; i++) fb[i] = '0;
            end
            if (!spi_cs_n && !prev_sck && spi_sck) begin
                if (ph_cnt < HALF_DIV && nr % 8 != 0) ph_bad++;
                ph_cnt = 0;
                in_sr = {in_sr[6:0], spi_mosi};
                nr++;
                if (nr % 8 == 0) begin
                    if (nbytes < 8) fb[nbytes] = in_sr;
                    nbytes++;
                end
            end
            if (!spi_cs_n && prev_sck && !spi_sck) begin
                if (ph_cnt != HALF_DIV) ph_bad++;
                ph_cnt = 0;
                if (nr % 8 == 0) begin
                    int hdr;
                    hdr = (fb[0] == 8'h03) ? 4 : (fb[0] == 8'h0B) ? 5 :
                          (fb[0] == 8'h05) ? 1 : 99;
                    out_b = 8'h00;
                    if (nr / 8 >= hdr) begin
                        if (fb[0] == 8'h05) begin
                            if (busy_left > 0) begin out_b = 8'h03; busy_left--; end
                        end else begin
                            out_b = mem_at({fb[1], fb[2], fb[3]} + 24'(nr / 8 - hdr));
                        end
                    end
                end
                spi_miso = out_b[7 - (nr % 8)];
            end
            if (!prev_cs && spi_cs_n) begin
                if (nf < 8) begin
                    log_op[nf] = fb[0];
                    log_addr[nf] = {fb[1], fb[2], fb[3]};
                    log_bits[nf] = nr;
                end
                nf++;
                if ((fb[0] == 8'h20 || fb[0] == 8'hD8) && nr == 32 && wel) begin
                    busy_left = busy_cfg; wel = 1'b0;
                end
                if (fb[0] == 8'h06 && nr == 8) wel = 1'b1;
                spi_miso = 1'b0;
                hi_run = 0;
            end
            if (rsp_valid) begin
                if (nrx < 16) rx_buf[nrx] = rsp_data;
                nrx++;
            end
            if (rsp_done) begin
                ndone++;
                if (!spi_cs_n || hi_run < GAP) done_bad++;
            end
            if (spi_cs_n) hi_run++;
            ph_cnt++;
            prev_sck = spi_sck;
            prev_cs = spi_cs_n;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        for (int i = 0; i < 20000 && ndone == 0; i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic issue(input int op, input logic [23:0] a, input int len);
        @(negedge clk);
        req_op = 2'(op); req_addr = a; req_len = CNT_W'(len); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic do_read(input int op, input logic [23:0] a, input int len);
        int hb;
        nf = 0; nrx = 0; ndone = 0;
        issue(op, a, len);
        finish_run();
        hb = (op == 1) ? 40 : 32;
        chk(op == 1 ? "R3 frame count" : "R2 frame count", nf, 1);
        chk(op == 1 ? "R3 opcode" : "R2 opcode", log_op[0], op == 1 ? 8'h0B : 8'h03);
        chk("R2 address", log_addr[0], a);
        chk(len == 0 ? "R10 frame bits" : "R2 frame bits", log_bits[0], hb + 8 * len);
        chk(len == 0 ? "R10 byte count" : "R2 byte count", nrx, len);
        for (int i = 0; i < len; i++)
            chk(op == 1 ? "R3 data" : "R2 data", rx_buf[i], mem_at(a + 24'(i)));
        chk(len == 0 ? "R10 done count" : "R8 done count", ndone, 1);
    endtask

    task automatic do_erase(input int op, input logic [23:0] a, input int k);
        nf = 0; nrx = 0; ndone = 0; busy_cfg = k;
        issue(op, a, 5);
        finish_run();
        chk("R4 frame count", nf, 3);
        chk("R4 wren opcode", log_op[0], 8'h06);
        chk("R4 wren bits", log_bits[0], 8);
        chk("R4 erase opcode", log_op[1], op == 2 ? 8'h20 : 8'hD8);
        chk("R4 erase address", log_addr[1], a);
        chk("R4 erase bits", log_bits[1], 32);
        chk("R5 poll opcode", log_op[2], 8'h05);
        chk("R5 poll bits", log_bits[2], 8 + 8 * (k + 1));
        chk("R5 no data strobes", nrx, 0);
        chk("R8 done count", ndone, 1);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [23:0] addrs [0:2];
        addrs[0] = 24'h000000; addrs[1] = 24'h0123FE; addrs[2] = 24'hFFFFFD;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sck", spi_sck, 0);
        chk("R1 mosi", spi_mosi, 0);
        chk("R1 valid", rsp_valid, 0);
        chk("R1 done", rsp_done, 0);

        for (int op = 0; op < 2; op++)
            for (int ai = 0; ai < 3; ai++)
                for (int len = 0; len < 5; len++)
                    do_read(op, addrs[ai], len);

        for (int op = 2; op < 4; op++)
            for (int k = 0; k < 4; k++)
                do_erase(op, addrs[k % 3] ^ 24'(k * 24'h011111), k);

        // R9: a start in the middle of a read is dropped
        nf = 0; nrx = 0; ndone = 0;
        issue(0, 24'h004410, 3);
        repeat (20) @(negedge clk);
        req_op = 2'd3; req_addr = 24'h070000; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        finish_run();
        repeat (200) @(negedge clk);
        chk("R9 frame count", nf, 1);
        chk("R9 opcode", log_op[0], 8'h03);
        chk("R9 byte count", nrx, 3);
        chk("R9 done count", ndone, 1);

        // bus timing collected over the whole run
        chk("R6 sck while cs high", idle_sck_bad, 0);
        chk("R6 phase length", ph_bad, 0);
        chk("R7 cs high gap", gap_bad, 0);
        chk("R8 done after gap", done_bad, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule